// File: doc/BRIEF.md
# Dual Four-Mode Timer/Counter

This block holds two timer/counter channels. Each channel has an 8-bit low count byte and an 8-bit high count byte. One mode byte configures both channels, and a control byte holds the run bits and overflow flags. A plain single-cycle register bus reads and writes all six registers. Each channel advances on one of two sources:

- a machine-cycle strobe `cyc_tick`, supplied from outside;
- a falling edge on its own event pin.

An external gate pin can hold a channel back, so the channel counts only while that pin is high.

A channel can count as a 13-bit prescaled counter, a 16-bit counter, or an 8-bit counter that reloads from its high byte. Channel 0 also has a split mode. In split mode its low byte becomes an independent 8-bit counter. Its high byte becomes an 8-bit timer, and that timer takes channel 1's run bit and overflow flag. Each overflow flag goes to an interrupt controller, which clears it with a one-cycle acknowledge pulse.

The register bus has no handshake. A write takes effect at the next clock edge. A read is combinational from `addr`. There is no streamed data path, so there is no back-pressure.

Top module: `tmr_pair`

## Requirements
- R1: After reset, all six registers read 00h and both overflow outputs are low.
- R2: The register addresses are: 0 = mode, 1 = control, 2/3 = channel 0 low/high, 4/5 = channel 1 low/high.
  - The mode byte holds channel 1 in bits 7:4 and channel 0 in bits 3:0. Each nibble is {gate, external-source, mode[1:0]}.
  - The control byte holds, in bits 7:4, flag1, run1, flag0, run0.
  - Control bits 3:0 always read 0, and writes to them are ignored.
- R3: With external-source = 0, an enabled channel advances once per clock edge on which `cyc_tick` is high.
- R4: With external-source = 1, an enabled channel advances on a `cyc_tick` edge where the event pin is 0 and the pin sampled at the previous `cyc_tick` was 1.
- R5: A channel is enabled when its run bit is 1 and either its gate bit is 0 or its `gate_pin` is high.
- R6: Mode 00 is the 13-bit mode.
  - Low bits 4:0 form a prescaler that carries into the high byte.
  - Overflow happens when the count goes from high FFh, prescaler 1Fh to zero.
  - Low bits 7:5 are never changed by counting.
- R7: Mode 01 is a 16-bit counter {high, low}. It overflows from FFFFh to 0000h.
- R8: Mode 10 is an 8-bit counter on the low byte. When the low byte at FFh steps, it loads the high byte and flags an overflow. The high byte does not change.
- R9: Mode 11 on channel 0 is the split mode.
  - The low byte is an 8-bit counter under channel 0's run, gate and source bits, and sets flag0.
  - The high byte advances on every `cyc_tick` while run1 is 1, ignoring gate and source bits, and sets flag1 when it wraps.
- R10: Mode 11 on channel 1 freezes both channel 1 count bytes.
- R11: An overflow sets the channel's flag.
  - An `irq_ack` pulse clears the flag, but a set in the same cycle wins over the clear.
  - A bus write to the control byte wins over both.
  - `ovf_flag` shows flag1 and flag0 directly.
- R12: A bus write to a count byte wins over counting of that byte in the same cycle. The other byte of the channel still updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_tick | input | 1 | Machine-cycle strobe, one clock wide |
| ev_pin | input | 2 | External event input per channel |
| gate_pin | input | 2 | External gate input per channel |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| irq_ack | input | 2 | Flag clear pulse per channel |
| ovf_flag | output | 2 | Overflow flags {flag1, flag0} |

## Verification
Each channel is loaded just below its wrap point in every mode. This separates the three carry structures: 13-bit prescale, 16-bit, and reload. The split mode is run with channel 0's run bit off, which shows that the borrowed run bit moves only the high byte. The event-pin source is driven with slow square waves, so an exact count of falling edges is expected. The gate pin is held low and then high under the same run bit, which separates gating from run control. Bus writes are placed on counting edges to show write priority, and acknowledges are placed beside overflows to show how set, clear and control-write conflicts resolve.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int REG_AW = 3;

  typedef enum logic [1:0] {
    MD_13    = 2'b00,
    MD_16    = 2'b01,
    MD_RLD   = 2'b10,
    MD_SPLIT = 2'b11
  } tmode_e;

  typedef struct packed {
    logic   gate;
    logic   ext;
    tmode_e md;
  } chcfg_t;

  localparam logic [REG_AW-1:0] A_MODE = 3'd0;
  localparam logic [REG_AW-1:0] A_CTRL = 3'd1;
  localparam logic [REG_AW-1:0] A_L0   = 3'd2;
  localparam logic [REG_AW-1:0] A_H0   = 3'd3;
  localparam logic [REG_AW-1:0] A_L1   = 3'd4;
  localparam logic [REG_AW-1:0] A_H1   = 3'd5;
endpackage

// File: rtl/tmr_evsel.sv
module tmr_evsel (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pin,
  input  logic gate_pin,
  input  logic gate,
  input  logic ext,
  input  logic run,
  output logic step
);
  logic smp_q;
  logic fall;

  // sample the event pin once per machine cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    smp_q <= 1'b0;
    else if (tick) smp_q <= pin;
  end

  assign fall = smp_q & ~pin;
  assign step = run & (~gate | gate_pin) & tick & (~ext | fall);
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int BYTE_W    = 8,
  parameter int PRE_W     = 5,
  parameter bit HAS_SPLIT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              hi_step,
  input  tmr_pkg::tmode_e   md,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] lo_q,
  output logic [BYTE_W-1:0] hi_q,
  output logic              ovf,
  output logic              hi_ovf
);
  import tmr_pkg::*;

  localparam logic [BYTE_W:0]   ONE_B = {{BYTE_W{1'b0}}, 1'b1};
  localparam logic [2*BYTE_W:0] ONE_W = {{(2*BYTE_W){1'b0}}, 1'b1};
  localparam logic [PRE_W:0]    ONE_P = {{PRE_W{1'b0}}, 1'b1};

  logic [BYTE_W-1:0] lo_n, hi_n;
  logic [PRE_W:0]    pre_sum;
  logic [BYTE_W:0]   hi_sum, lo_sum, hs_sum;
  logic [2*BYTE_W:0] w_sum;

  assign pre_sum = {1'b0, lo_q[PRE_W-1:0]} + ONE_P;
  assign hi_sum  = {1'b0, hi_q} + ONE_B;
  assign lo_sum  = {1'b0, lo_q} + ONE_B;
  assign w_sum   = {1'b0, hi_q, lo_q} + ONE_W;
  assign hs_sum  = hi_sum;

  always_comb begin
    lo_n   = lo_q;
    hi_n   = hi_q;
    ovf    = 1'b0;
    hi_ovf = 1'b0;
    unique case (md)
      MD_13: if (step) begin
        lo_n[PRE_W-1:0] = pre_sum[PRE_W-1:0];
        if (pre_sum[PRE_W]) begin
          hi_n = hi_sum[BYTE_W-1:0];
          ovf  = hi_sum[BYTE_W];
        end
      end
      MD_16: if (step) begin
        {hi_n, lo_n} = w_sum[2*BYTE_W-1:0];
        ovf          = w_sum[2*BYTE_W];
      end
      MD_RLD: if (step) begin
        if (lo_sum[BYTE_W]) begin
          lo_n = hi_q;
          ovf  = 1'b1;
        end else begin
          lo_n = lo_sum[BYTE_W-1:0];
        end
      end
      MD_SPLIT: if (HAS_SPLIT) begin
        if (step) begin
          lo_n = lo_sum[BYTE_W-1:0];
          ovf  = lo_sum[BYTE_W];
        end
        if (hi_step) begin
          hi_n   = hs_sum[BYTE_W-1:0];
          hi_ovf = hs_sum[BYTE_W];
        end
      end
      default: ;
    endcase
    if (wr_lo) lo_n = wdata;
    if (wr_hi) hi_n = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_n;
      hi_q <= hi_n;
    end
  end
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair #(
  parameter int BYTE_W = 8,
  parameter int PRE_W  = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cyc_tick,
  input  logic [1:0]                 ev_pin,
  input  logic [1:0]                 gate_pin,
  input  logic                       wr_en,
  input  logic [tmr_pkg::REG_AW-1:0] addr,
  input  logic [BYTE_W-1:0]          wdata,
  output logic [BYTE_W-1:0]          rdata,
  input  logic [1:0]                 irq_ack,
  output logic [1:0]                 ovf_flag
);
  import tmr_pkg::*;

  localparam int NCH = 2;
  localparam int NIB = 4;

  logic [2*NIB-1:0]  mode_q;
  logic [NCH-1:0]    run_q, flag_q, step_w, ovf_w, hi_ovf_w, set_w;
  logic [BYTE_W-1:0] lo_w [NCH];
  logic [BYTE_W-1:0] hi_w [NCH];
  chcfg_t            cfg  [NCH];
  logic              wr_ctrl;

  assign wr_ctrl = wr_en && (addr == A_CTRL);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [REG_AW-1:0] LO_A = (i == 0) ? A_L0 : A_L1;
    localparam logic [REG_AW-1:0] HI_A = (i == 0) ? A_H0 : A_H1;

    assign cfg[i] = chcfg_t'(mode_q[i*NIB +: NIB]);

    tmr_evsel u_ev (
      .clk(clk), .rst_n(rst_n), .tick(cyc_tick), .pin(ev_pin[i]),
      .gate_pin(gate_pin[i]), .gate(cfg[i].gate), .ext(cfg[i].ext),
      .run(run_q[i]), .step(step_w[i])
    );

    tmr_chan #(.BYTE_W(BYTE_W), .PRE_W(PRE_W), .HAS_SPLIT(i == 0)) u_chan (
      .clk(clk), .rst_n(rst_n), .step(step_w[i]),
      .hi_step(cyc_tick & run_q[1]), .md(cfg[i].md),
      .wr_lo(wr_en && (addr == LO_A)), .wr_hi(wr_en && (addr == HI_A)),
      .wdata(wdata), .lo_q(lo_w[i]), .hi_q(hi_w[i]),
      .ovf(ovf_w[i]), .hi_ovf(hi_ovf_w[i])
    );
  end

  // split high half of channel 0 reports through flag 1
  assign set_w = {ovf_w[1] | hi_ovf_w[0], ovf_w[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      run_q  <= '0;
      flag_q <= '0;
    end else begin
      if (wr_en && (addr == A_MODE)) mode_q <= wdata[2*NIB-1:0];
      if (wr_ctrl) begin
        {flag_q[1], run_q[1], flag_q[0], run_q[0]} <= wdata[7:4];
      end else begin
        for (int i = 0; i < NCH; i++) begin
          if (set_w[i])        flag_q[i] <= 1'b1;
          else if (irq_ack[i]) flag_q[i] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    unique case (addr)
      A_MODE:  rdata = mode_q;
      A_CTRL:  rdata = {flag_q[1], run_q[1], flag_q[0], run_q[0], 4'b0000};
      A_L0:    rdata = lo_w[0];
      A_H0:    rdata = hi_w[0];
      A_L1:    rdata = lo_w[1];
      A_H1:    rdata = hi_w[1];
      default: rdata = '0;
    endcase
  end

  assign ovf_flag = flag_q;
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [2:0] addr,
  input logic [7:0] wdata,
  input logic [1:0] gate_pin,
  input logic [1:0] irq_ack,
  input logic [1:0] ovf_flag,
  input logic [7:0] mode_q,
  input logic [1:0] ovf_w,
  input logic [1:0] hi_ovf_w,
  input logic [7:0] lo0,
  input logic [7:0] hi0,
  input logic [7:0] lo1,
  input logic [7:0] hi1
);
  logic wr_c, wr_ch0, wr_ch1;
  assign wr_c   = wr_en && addr == 3'd1;
  assign wr_ch0 = wr_en && (addr == 3'd2 || addr == 3'd3);
  assign wr_ch1 = wr_en && (addr == 3'd4 || addr == 3'd5);

  assert_ctrl_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_c |=> ovf_flag == {$past(wdata[7]), $past(wdata[5])});

  assert_flag_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovf_flag[0]) |-> $past(irq_ack[0] || wr_c));

  assert_flag_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag[1]) |-> $past(ovf_w[1] || hi_ovf_w[0] || wr_c));

  assert_write_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd2) |=> lo0 == $past(wdata));

  assert_ch1_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[5:4] == 2'b11 && !wr_ch1) |=> $stable({hi1, lo1}));

  assert_prescale_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[1:0] == 2'b00 && !(wr_en && addr == 3'd2)) |=> $stable(lo0[7:5]));

  assert_gate_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[3] && !gate_pin[0] && mode_q[1:0] != 2'b11 && !wr_ch0)
      |=> $stable({hi0, lo0}));
endmodule

bind tmr_pair tmr_pair_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .gate_pin(gate_pin), .irq_ack(irq_ack), .ovf_flag(ovf_flag),
  .mode_q(mode_q), .ovf_w(ovf_w), .hi_ovf_w(hi_ovf_w),
  .lo0(lo_w[0]), .hi0(hi_w[0]), .lo1(lo_w[1]), .hi1(hi_w[1])
);

// File: tb/tmr_pair_tb.sv
module tmr_pair_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_tick = 1'b0;
  logic [1:0] ev_pin = '0, gate_pin = '0, irq_ack = '0, ovf_flag;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata;

  tmr_pair u_dut (
    .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .ev_pin(ev_pin),
    .gate_pin(gate_pin), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq_ack(irq_ack), .ovf_flag(ovf_flag)
  );

  always #10 clk = ~clk;

  int checks = 0, failures = 0, tcnt = 0, rd_ptr = 0;
  bit done = 0, live = 0;
  logic [1:0] ack_req = '0;
  string cur_tag = "R1";

  // behavioural reference state
  int m_mode = 0;
  int m_lo[2], m_hi[2], m_tr[2], m_tf[2], m_smp[2];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int model_reg(input int a);
    case (a)
      0: return m_mode;
      1: return m_tf[1]*128 + m_tr[1]*64 + m_tf[0]*32 + m_tr[0]*16;
      2: return m_lo[0];
      3: return m_hi[0];
      4: return m_lo[1];
      5: return m_hi[1];
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin : model
    int nlo[2], nhi[2];
    bit ov[2], hov, en, ev, st;
    int g, ct, md, sum;
    if (!rst_n) begin
      m_mode = 0;
      for (int i = 0; i < 2; i++) begin
        m_lo[i] = 0; m_hi[i] = 0; m_tr[i] = 0; m_tf[i] = 0; m_smp[i] = 0;
      end
    end else begin
      hov = 0;
      for (int i = 0; i < 2; i++) begin
        g  = (m_mode >> (4*i+3)) & 1;
        ct = (m_mode >> (4*i+2)) & 1;
        md = (m_mode >> (4*i)) & 3;
        en = m_tr[i] != 0 && (g == 0 || gate_pin[i]);
        ev = cyc_tick && (ct == 0 || (m_smp[i] == 1 && ev_pin[i] == 1'b0));
        st = en && ev;
        nlo[i] = m_lo[i]; nhi[i] = m_hi[i]; ov[i] = 0;
        if (st) begin
          if (md == 0) begin
            sum = (m_lo[i] % 32) + 1;
            if (sum == 32) begin
              sum = 0;
              nhi[i] = (m_hi[i] + 1) % 256;
              ov[i] = (m_hi[i] == 255);
            end
            nlo[i] = (m_lo[i] / 32) * 32 + sum;
          end else if (md == 1) begin
            sum = m_hi[i] * 256 + m_lo[i] + 1;
            ov[i] = (sum == 65536);
            sum = sum % 65536;
            nhi[i] = sum / 256; nlo[i] = sum % 256;
          end else if (md == 2) begin
            if (m_lo[i] == 255) begin nlo[i] = m_hi[i]; ov[i] = 1; end
            else nlo[i] = m_lo[i] + 1;
          end else if (i == 0) begin
            ov[i] = (m_lo[i] == 255);
            nlo[i] = (m_lo[i] + 1) % 256;
          end
        end
      end
      if ((m_mode & 3) == 3 && cyc_tick && m_tr[1] != 0) begin
        hov = (m_hi[0] == 255);
        nhi[0] = (m_hi[0] + 1) % 256;
      end
      for (int i = 0; i < 2; i++) if (cyc_tick) m_smp[i] = ev_pin[i];
      if (wr_en) begin
        if (addr == 2) nlo[0] = wdata;
        if (addr == 3) nhi[0] = wdata;
        if (addr == 4) nlo[1] = wdata;
        if (addr == 5) nhi[1] = wdata;
      end
      for (int i = 0; i < 2; i++) begin m_lo[i] = nlo[i]; m_hi[i] = nhi[i]; end
      if (wr_en && addr == 1) begin
        m_tf[1] = wdata[7]; m_tr[1] = wdata[6]; m_tf[0] = wdata[5]; m_tr[0] = wdata[4];
      end else begin
        if (ov[0]) m_tf[0] = 1; else if (irq_ack[0]) m_tf[0] = 0;
        if (ov[1] || hov) m_tf[1] = 1; else if (irq_ack[1]) m_tf[1] = 0;
      end
      if (wr_en && addr == 0) m_mode = wdata;
    end
  end

  // one bus cycle: compare at the falling edge, then drive the next inputs
  task automatic cyc(input bit wr, input int a, input int d);
    int exp;
    @(negedge clk);
    if (live) begin
      exp = model_reg(addr);
      chk(rdata == exp[7:0], (addr == 0) ? "R2 mode" : (addr == 1) ? "R11 ctrl" : cur_tag,
          rdata, exp);
      chk(ovf_flag == {m_tf[1][0], m_tf[0][0]}, "R11 flags", ovf_flag,
          {m_tf[1][0], m_tf[0][0]});
    end
    cyc_tick = (tcnt % 3 == 0);
    tcnt++;
    wr_en = wr;
    wdata = d[7:0];
    irq_ack = ack_req;
    ack_req = '0;
    if (wr || a < 6) addr = a[2:0];
    else begin addr = rd_ptr[2:0]; rd_ptr = (rd_ptr + 1) % 6; end
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) cyc(0, 7, 0);
  endtask

  task automatic wr(input int a, input int d);
    cyc(1, a, d);
  endtask

  task automatic peek(input int a, output int v);
    cyc(0, a, 0);
    #1 v = rdata;
  endtask

  initial begin
    #(20 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      peek(a, v);
      chk(v == 0, "R1 reset reg", v, 0);
    end
    chk(ovf_flag == 2'b00, "R1 reset flags", ovf_flag, 0);
    live = 1;

    // R7 16-bit wrap
    cur_tag = "R7";
    wr(0, 8'h01); wr(2, 8'hF0); wr(3, 8'hFF); wr(1, 8'h10);
    run(80);
    chk(ovf_flag[0] == 1'b1, "R7 wrap flag", ovf_flag[0], 1);
    wr(1, 8'h10);  // keeps run, clears flag via control write (R11)
    chk(1'b1, "R11", 0, 0);
    ack_req = 2'b01; run(2);
    chk(ovf_flag[0] == 1'b0, "R11 ack clear", ovf_flag[0], 0);

    // R6 13-bit prescale
    cur_tag = "R6";
    wr(1, 0); wr(0, 8'h00); wr(2, 8'hFC); wr(3, 8'hFF); wr(1, 8'h10);
    run(30);
    chk(ovf_flag[0] == 1'b1, "R6 overflow", ovf_flag[0], 1);
    peek(2, v);
    chk(v[7:5] == 3'b111, "R6 upper low bits kept", v[7:5], 7);
    ack_req = 2'b01; run(3);

    // R8 auto-reload
    cur_tag = "R8";
    wr(1, 0); wr(0, 8'h02); wr(3, 8'hF8); wr(2, 8'hF8); wr(1, 8'h10);
    run(60);
    peek(3, v);
    chk(v == 8'hF8, "R8 high kept", v, 8'hF8);
    chk(ovf_flag[0] == 1'b1, "R8 reload flag", ovf_flag[0], 1);

    // R5 gating
    cur_tag = "R5";
    wr(1, 0); wr(0, 8'h09); wr(2, 8'h10); wr(3, 0); gate_pin = 2'b00; wr(1, 8'h10);
    run(30);
    peek(2, v);
    chk(v == 8'h10, "R5 gate low holds", v, 8'h10);
    gate_pin = 2'b01;
    run(30);
    peek(2, v);
    chk(v != 8'h10, "R5 gate high counts", v, 8'h10);

    // R4 external falling edges
    cur_tag = "R4";
    wr(1, 0); wr(0, 8'h05); wr(2, 0); wr(3, 0); ev_pin = 2'b00; wr(1, 8'h10);
    for (int k = 0; k < 5; k++) begin
      ev_pin[0] = 1'b1; run(12);
      ev_pin[0] = 1'b0; run(12);
    end
    peek(2, v);
    chk(v == 5, "R4 edge count", v, 5);

    // R3 timer on channel 1
    cur_tag = "R3";
    wr(1, 0); wr(0, 8'h10); wr(4, 0); wr(5, 0); wr(1, 8'h40);
    run(30);
    peek(4, v);
    chk(v == 10, "R3 tick count", v, 10);

    // R9 split mode: high half borrows run1 and flag1
    cur_tag = "R9";
    wr(1, 0); wr(0, 8'h03); wr(3, 8'hFD); wr(2, 8'h40); wr(1, 8'h40);
    run(30);
    chk(ovf_flag[1] == 1'b1, "R9 high sets flag1", ovf_flag[1], 1);
    peek(2, v);
    chk(v == 8'h40, "R9 low idle without run0", v, 8'h40);

    // R10 channel 1 frozen
    cur_tag = "R10";
    wr(1, 0); wr(0, 8'h30); wr(4, 8'h55); wr(1, 8'h40);
    run(30);
    peek(4, v);
    chk(v == 8'h55, "R10 channel 1 frozen", v, 8'h55);

    // R12 write beats increment
    cur_tag = "R12";
    wr(1, 0); wr(0, 8'h01); wr(1, 8'h10);
    run(5);
    wr(2, 8'hAA); wr(2, 8'hAA); wr(2, 8'hAA);
    peek(2, v);
    chk(v == 8'hAA, "R12 write wins", v, 8'hAA);

    // R11 set/ack conflicts and control write
    cur_tag = "R11";
    wr(1, 0); wr(0, 8'h02); wr(3, 8'hFF); wr(2, 8'hFF); wr(1, 8'h10);
    for (int k = 0; k < 12; k++) begin ack_req = 2'b01; run(1); end
    wr(1, 8'hA0);
    run(1);
    chk(ovf_flag == 2'b11, "R11 control write sets flags", ovf_flag, 3);
    wr(1, 8'h0F);
    peek(1, v);
    chk(v == 0, "R2 low control bits ignored", v, 0);
    run(6);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule